// File: doc/BRIEF.md
# Interrupt and Stack Entry Sequencer

This block is the part of an 8-bit processor core that moves control into and out of exception handlers. It owns the 16-bit program counter, the 8-bit stack pointer and the status flags. A one-cycle `start` pulse with a cause code asks for one of five sequences: a reset load, a non-maskable interrupt, a maskable interrupt, a software break, or a return from interrupt. The block then runs a fixed sequence of cycles on a byte-wide synchronous memory port and pulses `done` in the last cycle of the sequence.

An entry sequence saves the return context on the stack, which lives in page one. It writes the PC high byte, then the PC low byte, then the status byte, and the pointer steps down after each write. It then sets the interrupt-disable flag and reads a two-byte handler address from a fixed vector near the top of memory. A return sequence reads the status, the PC low byte and the PC high byte back from the stack, and the pointer steps up after each read. The memory port is synchronous: a byte is returned on `mem_rdata` in the cycle after its address was presented.

Top module: `trap_sequencer`

## Requirements
- R1: After `rst`, `pc` is 0x0000, `sp` is 0xFF, `status` is 0x24, `busy` and `done` are low and `mem_we` is low.
- R2: A reset cause (code 0) performs no memory write. It reads 0xFFFC and then 0xFFFD, loads `pc` with {byte at 0xFFFD, byte at 0xFFFC}, sets `status` bit 2, leaves `sp` unchanged, and raises `done` in the third cycle after acceptance.
- R3: An entry cause writes three bytes at addresses {0x01, sp}, in the order PC high, PC low, status. `sp` decreases by one after each write and wraps modulo 256.
- R4: The status byte that an entry writes has bit 5 set. Its bit 4 is 1 for a break (code 3) and 0 for NMI (code 1) and IRQ (code 2). Its other bits equal `status`.
- R5: An entry reads its vector low byte first and then the high byte: at 0xFFFA/0xFFFB for NMI, and at 0xFFFE/0xFFFF for IRQ and break.
- R6: An entry raises `done` in the seventh cycle after acceptance. The new `pc` and `status` bit 2 set are visible in the cycle after `done`.
- R7: An IRQ start while `status` bit 2 is 1 is ignored, with no busy cycle, no write and no state change. An NMI is accepted whatever the value of bit 2.
- R8: A return (code 4) reads {0x01, sp+1}, {0x01, sp+2} and {0x01, sp+3}, with wrap inside the page. It loads `status` from the first byte, with bits 7, 6, 3, 2, 1 and 0 taken from the byte, bit 5 reading 1 and bit 4 reading 0. It loads `pc` as {third, second}, increases `sp` by 3, and raises `done` in the sixth cycle after acceptance.
- R9: A start while `busy` is high, or with an undefined code (5 to 7), is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sequence request, sampled while idle |
| cause | input | 3 | Request code: 0 reset, 1 NMI, 2 IRQ, 3 break, 4 return |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data, zero when not writing |
| mem_we | output | 1 | Write strobe |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer (low byte of the stack address) |
| status | output | 8 | Status flags, bit 2 = interrupt disable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |

## Verification
Each cause code is issued and the bus is compared cycle by cycle against a behavioural model. This separates the three vector pairs and the B bit that marks a break from an IRQ in the pushed byte. An IRQ is tried both with the mask set and with it clear, and an NMI is tried with the mask set, to show that the gating applies only to the maskable request. A return is taken from a pointer of 0xFF so that its reads wrap inside page one, and the entries that follow push across the 0x00/0xFF boundary. Requests arriving mid-sequence and undefined codes are sent to show that they leave the bus and the registers unchanged.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // status bit positions
    localparam int FLAG_I   = 2;
    localparam int FLAG_BRK = 4;
    localparam int FLAG_ONE = 5;

    localparam logic [DATA_W-1:0] STATUS_RESET = 8'h24;
    localparam logic [DATA_W-1:0] STATUS_KEEP  = 8'hCF;
    localparam logic [DATA_W-1:0] STATUS_ONE   = 8'h20;

    typedef enum logic [2:0] {
        CAUSE_RESET = 3'd0,
        CAUSE_NMI   = 3'd1,
        CAUSE_IRQ   = 3'd2,
        CAUSE_BRK   = 3'd3,
        CAUSE_RTI   = 3'd4
    } cause_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTRY_GAP,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_STAT,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_LOAD,
        ST_RET_GAP0,
        ST_RET_GAP1,
        ST_PULL_STAT,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_PULL_LOAD
    } seq_state_e;

    function automatic logic cause_known(input logic [2:0] c);
        return c <= 3'd4;
    endfunction

    // low byte address of the vector pair for a cause; vec_top is the last byte of memory
    function automatic logic [ADDR_W-1:0] vector_lo(input cause_e c, input logic [ADDR_W-1:0] vec_top);
        case (c)
            CAUSE_NMI:   return vec_top - 16'd5;
            CAUSE_RESET: return vec_top - 16'd3;
            default:     return vec_top - 16'd1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pushed_status(input logic [DATA_W-1:0] flags, input logic is_brk);
        logic [DATA_W-1:0] s;
        s = (flags & STATUS_KEEP) | STATUS_ONE;
        s[FLAG_BRK] = is_brk;
        return s;
    endfunction

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
    import trap_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  cause_in,
    input  logic        irq_masked,
    output seq_state_e  state,
    output cause_e      kind
);

    logic accept;
    seq_state_e state_n;

    assign accept = start && (state == ST_IDLE) && cause_known(cause_in)
                    && !((cause_in == CAUSE_IRQ) && irq_masked);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (cause_in == CAUSE_RESET)    state_n = ST_VEC_LO;
                    else if (cause_in == CAUSE_RTI) state_n = ST_RET_GAP0;
                    else                            state_n = ST_ENTRY_GAP;
                end
            end
            ST_ENTRY_GAP: state_n = ST_PUSH_HI;
            ST_PUSH_HI:   state_n = ST_PUSH_LO;
            ST_PUSH_LO:   state_n = ST_PUSH_STAT;
            ST_PUSH_STAT: state_n = ST_VEC_LO;
            ST_VEC_LO:    state_n = ST_VEC_HI;
            ST_VEC_HI:    state_n = ST_VEC_LOAD;
            ST_VEC_LOAD:  state_n = ST_IDLE;
            ST_RET_GAP0:  state_n = ST_RET_GAP1;
            ST_RET_GAP1:  state_n = ST_PULL_STAT;
            ST_PULL_STAT: state_n = ST_PULL_LO;
            ST_PULL_LO:   state_n = ST_PULL_HI;
            ST_PULL_HI:   state_n = ST_PULL_LOAD;
            ST_PULL_LOAD: state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= CAUSE_RESET;
        end else begin
            state <= state_n;
            if (accept) kind <= cause_e'(cause_in);
        end
    end

endmodule

// File: rtl/trap_seq_ctx.sv
module trap_seq_ctx
    import trap_seq_pkg::*;
#(
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter logic [7:0]        SP_INIT    = 8'hFF,
    parameter logic [ADDR_W-1:0] PC_INIT    = 16'h0000,
    parameter logic [ADDR_W-1:0] VEC_TOP    = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  cause_e            kind,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc,
    output logic [7:0]        sp,
    output logic [DATA_W-1:0] flags
);

    logic [DATA_W-1:0] lo_q;
    logic [7:0]        sp_inc;
    logic [ADDR_W-1:0] vec_addr;

    assign sp_inc   = sp + 8'd1;
    assign vec_addr = vector_lo(kind, VEC_TOP);

    always_comb begin
        mem_addr  = pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (state)
            ST_PUSH_HI: begin
                mem_addr = {STACK_PAGE, sp}; mem_we = 1'b1; mem_wdata = pc[15:8];
            end
            ST_PUSH_LO: begin
                mem_addr = {STACK_PAGE, sp}; mem_we = 1'b1; mem_wdata = pc[7:0];
            end
            ST_PUSH_STAT: begin
                mem_addr = {STACK_PAGE, sp}; mem_we = 1'b1;
                mem_wdata = pushed_status(flags, kind == CAUSE_BRK);
            end
            ST_PULL_STAT, ST_PULL_LO, ST_PULL_HI: mem_addr = {STACK_PAGE, sp_inc};
            ST_VEC_LO: mem_addr = vec_addr;
            ST_VEC_HI: mem_addr = vec_addr + 16'd1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= PC_INIT;
            sp    <= SP_INIT;
            flags <= STATUS_RESET;
            lo_q  <= '0;
        end else begin
            unique case (state)
                ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_STAT: sp <= sp - 8'd1;
                ST_VEC_LO:    flags[FLAG_I] <= 1'b1;
                ST_VEC_HI:    lo_q <= mem_rdata;
                ST_VEC_LOAD:  pc <= {mem_rdata, lo_q};
                ST_PULL_STAT: sp <= sp_inc;
                ST_PULL_LO: begin
                    sp    <= sp_inc;
                    flags <= (mem_rdata & STATUS_KEEP) | STATUS_ONE;
                end
                ST_PULL_HI: begin
                    sp   <= sp_inc;
                    lo_q <= mem_rdata;
                end
                ST_PULL_LOAD: pc <= {mem_rdata, lo_q};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_seq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  SP_INIT    = 8'hFF,
    parameter logic [15:0] PC_INIT    = 16'h0000,
    parameter logic [15:0] VEC_TOP    = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  cause,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic [15:0] pc,
    output logic [7:0]  sp,
    output logic [7:0]  status,
    output logic        busy,
    output logic        done
);

    seq_state_e state_q;
    cause_e     kind_q;

    trap_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cause_in   (cause),
        .irq_masked (status[FLAG_I]),
        .state      (state_q),
        .kind       (kind_q)
    );

    trap_seq_ctx #(
        .STACK_PAGE (STACK_PAGE),
        .SP_INIT    (SP_INIT),
        .PC_INIT    (PC_INIT),
        .VEC_TOP    (VEC_TOP)
    ) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .state     (state_q),
        .kind      (kind_q),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .pc        (pc),
        .sp        (sp),
        .flags     (status)
    );

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_VEC_LOAD) || (state_q == ST_PULL_LOAD);

endmodule

// File: rtl/trap_sequencer_checker.sv
module trap_sequencer_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  cause,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic [7:0]  sp,
    input logic [7:0]  status,
    input logic        busy,
    input logic        done,
    input logic [2:0]  kind
);

    p_push_page_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] == 8'h01));

    p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 8'd1));

    p_masked_irq_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cause == 3'd2 && status[2]) |=> !busy);

    p_entry_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (done && kind != 3'd4) |=> status[2]);

    p_done_last_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

    p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cause > 3'd4) |=> !busy);

endmodule

bind trap_sequencer trap_sequencer_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cause    (cause),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .sp       (sp),
    .status   (status),
    .busy     (busy),
    .done     (done),
    .kind     (kind_q)
);

// File: tb/trap_sequencer_tb.sv
`timescale 1ns/1ps
module trap_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst, start;
    logic [2:0]  cause;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr, pc;
    logic [7:0]  mem_wdata, sp, status;
    logic        mem_we, busy, done;

    int checks = 0;
    int fails  = 0;

    logic [7:0] bus_mem [int];
    logic [7:0] ref_mem [int];

    logic [15:0] m_pc;
    logic [7:0]  m_sp, m_st;

    always #2.5 clk = ~clk;

    trap_sequencer u_dut (
        .clk(clk), .rst(rst), .start(start), .cause(cause),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .pc(pc), .sp(sp), .status(status),
        .busy(busy), .done(done)
    );

    // synchronous byte memory
    always @(posedge clk) begin
        mem_rdata <= bus_mem.exists(int'(mem_addr)) ? bus_mem[int'(mem_addr)] : 8'h00;
        if (mem_we) bus_mem[int'(mem_addr)] = mem_wdata;
    end

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        bus_mem[int'(a)] = d;
        ref_mem[int'(a)] = d;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(busy == 1'b0, tag, "busy", 16'(busy), 16'h0);
        chk(pc == m_pc, tag, "pc", pc, m_pc);
        chk(sp == m_sp, tag, "sp", 16'(sp), 16'(m_sp));
        chk(status == m_st, tag, "status", 16'(status), 16'(m_st));
    endtask

    // request that must leave everything untouched
    task automatic ignored(input logic [2:0] c, input string tag);
        @(negedge clk); start = 1'b1; cause = c;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b0, tag, "busy after ignored start", 16'(busy), 16'h0);
        chk(mem_we == 1'b0, tag, "write after ignored start", 16'(mem_we), 16'h0);
        @(negedge clk);
        check_regs(tag);
    endtask

    // full sequence, compared cycle by cycle against the model
    task automatic run_op(input logic [2:0] c, input bit intrude, input string tag);
        int n;
        logic [15:0] ea [1:7];
        bit          ec [1:7];
        bit          ew [1:7];
        logic [7:0]  ed [1:7];
        string       et [1:7];
        logic [15:0] v;
        logic [7:0]  lo, ps;
        for (int k = 1; k <= 7; k++) begin
            ea[k] = '0; ec[k] = 0; ew[k] = 0; ed[k] = '0; et[k] = tag;
        end
        v = (c == 3'd1) ? 16'hFFFA : (c == 3'd0) ? 16'hFFFC : 16'hFFFE;
        if (c == 3'd0) begin
            n = 3;
            ea[1] = v; ec[1] = 1; ea[2] = v + 16'd1; ec[2] = 1;
            m_pc = {ref_rd(v + 16'd1), ref_rd(v)};
            m_st = m_st | 8'h04;
        end else if (c == 3'd4) begin
            n = 6;
            for (int k = 3; k <= 5; k++) begin
                ea[k] = {8'h01, 8'(m_sp + 8'(k - 2))}; ec[k] = 1;
            end
            m_st = (ref_rd(ea[3]) & 8'hCF) | 8'h20;
            m_pc = {ref_rd(ea[5]), ref_rd(ea[4])};
            m_sp = m_sp + 8'd3;
        end else begin
            n = 7;
            ps = (m_st & 8'hCF) | 8'h20 | ((c == 3'd3) ? 8'h10 : 8'h00);
            ed[2] = m_pc[15:8]; ed[3] = m_pc[7:0]; ed[4] = ps; et[4] = "R4";
            for (int k = 2; k <= 4; k++) begin
                ea[k] = {8'h01, m_sp}; ec[k] = 1; ew[k] = 1;
                ref_mem[int'(ea[k])] = ed[k];
                m_sp = m_sp - 8'd1;
            end
            ea[5] = v; ec[5] = 1; ea[6] = v + 16'd1; ec[6] = 1;
            et[5] = "R5"; et[6] = "R5";
            m_pc = {ref_rd(v + 16'd1), ref_rd(v)};
            m_st = m_st | 8'h04;
        end
        @(negedge clk); start = 1'b1; cause = c;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            chk(busy == 1'b1, tag, "busy", 16'(busy), 16'h1);
            chk(mem_we == ew[k], et[k], "write strobe", 16'(mem_we), 16'(ew[k]));
            if (ec[k]) chk(mem_addr == ea[k], et[k], "address", mem_addr, ea[k]);
            if (ew[k]) chk(mem_wdata == ed[k], et[k], "write data", 16'(mem_wdata), 16'(ed[k]));
            chk(done == (k == n), (n == 7) ? "R6" : tag, "done", 16'(done), 16'(k == n));
            start = intrude && (k == 2);
            if (intrude) cause = 3'd4;
        end
        @(negedge clk);
        check_regs((n == 7) ? "R6" : tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cause = 3'd0;
        poke(16'hFFFA, 8'h34); poke(16'hFFFB, 8'h12);
        poke(16'hFFFC, 8'h00); poke(16'hFFFD, 8'hC0);
        poke(16'hFFFE, 8'h78); poke(16'hFFFF, 8'h56);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pc = 16'h0000; m_sp = 8'hFF; m_st = 8'h24;
        // R1: reset state
        check_regs("R1");
        chk(done == 1'b0, "R1", "done", 16'(done), 16'h0);
        chk(mem_we == 1'b0, "R1", "write strobe", 16'(mem_we), 16'h0);

        ignored(3'd2, "R7");            // IRQ masked after reset
        run_op(3'd0, 0, "R2");          // reset vector load
        // stack image for a return from sp=0xFF: status clears the mask
        poke(16'h0100, 8'hC3); poke(16'h0101, 8'h11); poke(16'h0102, 8'h90);
        run_op(3'd4, 0, "R8");          // pulls wrap to 0x0100..0x0102
        run_op(3'd2, 0, "R3");          // IRQ accepted, pushes wrap 0x02 -> 0xFF
        ignored(3'd2, "R7");            // masked again
        run_op(3'd1, 1, "R9");          // NMI under mask, with a start intruding mid-way (R7)
        ignored(3'd6, "R9");
        ignored(3'd5, "R9");
        run_op(3'd3, 0, "R4");          // break marks bit 4
        run_op(3'd4, 0, "R8");          // return from break
        run_op(3'd4, 0, "R8");          // return from NMI frame
        run_op(3'd0, 0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule